// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block sits between the compare-match logic of an 8-bit timer and one general-purpose I/O pin, in non-PWM operation. It keeps a one-bit output-compare state of its own, separate from the pin. A compare-match strobe or a force strobe updates that bit. A 2-bit mode field decides what the update does: nothing, toggle, clear or set. A synchronous load can also write the bit directly, so software can place it at a known level before the pin is handed over.

The same mode field chooses what drives the pin. When the mode is nonzero, the state bit replaces the port data bit. When the mode is zero, the pin follows the port data bit. The direction bit alone decides whether the pin is driven, even while the override is active.

The state bit is modelled as a two-state machine. Its states are `OC_LOW` and `OC_HIGH`. Its transitions are named as follows:
- LOAD: go to the loaded value.
- TOGGLE: go to the opposite state.
- CLEAR: go to `OC_LOW`.
- SET: go to `OC_HIGH`.
- HOLD: stay in the current state.

Top module: `cmp_pin_unit`

## Requirements
- R1: While reset (`rst_ni` low) is asserted, the state bit `cmp_state_o` is 0 (state `OC_LOW`).
- R2: With mode 2'b01, a strobe with no load inverts `cmp_state_o` at the next clock edge (TOGGLE).
- R3: With mode 2'b10, a strobe with no load makes `cmp_state_o` 0 at the next clock edge (CLEAR).
- R4: With mode 2'b11, a strobe with no load makes `cmp_state_o` 1 at the next clock edge (SET).
- R5: With mode 2'b00, a strobe leaves `cmp_state_o` unchanged (HOLD).
- R6: `force_i` alone causes exactly the same state action as `match_i` alone for every mode.
- R7: When `match_i` and `force_i` are high in the same cycle, the mode action is applied once. In toggle mode the bit therefore inverts exactly once.
- R8: `load_i` high writes `load_val_i` into `cmp_state_o` at the next edge (LOAD). It does this for every mode, and it overrides any strobe in the same cycle.
- R9: When `mode_i` is nonzero, `pin_out_o` equals `cmp_state_o`. When `mode_i` is 2'b00, `pin_out_o` equals `port_data_i`.
- R10: `pin_oe_o` always equals `port_dir_i`, whatever the mode.
- R11: With no strobe and no load, `cmp_state_o` keeps its value (HOLD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Compare output mode: 00 off, 01 toggle, 10 clear, 11 set |
| match_i | input | 1 | One-cycle compare-match strobe |
| force_i | input | 1 | One-cycle force-compare strobe |
| load_i | input | 1 | Synchronous direct write of the state bit |
| load_val_i | input | 1 | Value written by `load_i` |
| port_data_i | input | 1 | Port data bit used when the override is off |
| port_dir_i | input | 1 | Data-direction bit, 1 = output |
| pin_out_o | output | 1 | Value presented to the pin driver |
| pin_oe_o | output | 1 | Pin output enable |
| cmp_state_o | output | 1 | Internal output-compare state bit |

## Verification
The assertions assume the strobes and the load are sampled only at rising edges. They also assume `mode_i` is stable around the edge at which it is sampled. The pin-source property is combinational, so it further assumes that `mode_i` and `port_data_i` settle before the edge. The bench keeps within these assumptions by changing every input on the falling edge and by raising the strobes for exactly one cycle. It also holds the mode steady across each strobe.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        CM_OFF    = 2'b00,
        CM_TOGGLE = 2'b01,
        CM_CLEAR  = 2'b10,
        CM_SET    = 2'b11
    } cmp_mode_e;

    typedef enum logic {
        OC_LOW  = 1'b0,
        OC_HIGH = 1'b1
    } oc_state_e;

endpackage

// File: rtl/cmp_pin_next.sv
module cmp_pin_next
    import cmp_pin_pkg::*;
(
    input  oc_state_e cur_i,
    input  cmp_mode_e mode_i,
    input  logic      strobe_i,
    input  logic      load_i,
    input  logic      load_val_i,
    output oc_state_e nxt_o
);

    // LOAD wins over any strobe. A strobe then applies the mode transition.
    always_comb begin
        nxt_o = cur_i;
        if (load_i) begin
            nxt_o = load_val_i ? OC_HIGH : OC_LOW;
        end else if (strobe_i) begin
            unique case (mode_i)
                CM_OFF:    nxt_o = cur_i;
                CM_TOGGLE: nxt_o = (cur_i == OC_HIGH) ? OC_LOW : OC_HIGH;
                CM_CLEAR:  nxt_o = OC_LOW;
                CM_SET:    nxt_o = OC_HIGH;
                default:   nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
    import cmp_pin_pkg::*;
(
    input  cmp_mode_e mode_i,
    input  oc_state_e state_i,
    input  logic      port_data_i,
    input  logic      port_dir_i,
    output logic      pin_out_o,
    output logic      pin_oe_o
);

    logic override;

    always_comb begin
        override  = (mode_i != CM_OFF);
        pin_out_o = override ? (state_i == OC_HIGH) : port_data_i;
        pin_oe_o  = port_dir_i;
    end

endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
    import cmp_pin_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       match_i,
    input  logic       force_i,
    input  logic       load_i,
    input  logic       load_val_i,
    input  logic       port_data_i,
    input  logic       port_dir_i,
    output logic       pin_out_o,
    output logic       pin_oe_o,
    output logic       cmp_state_o
);

    cmp_mode_e mode;
    oc_state_e state_q;
    oc_state_e state_d;
    logic      strobe;

    always_comb begin
        mode   = cmp_mode_e'(mode_i);
        // Both strobes together form one event, so the action happens once.
        strobe = match_i | force_i;
    end

    cmp_pin_next u_next (
        .cur_i      (state_q),
        .mode_i     (mode),
        .strobe_i   (strobe),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .nxt_o      (state_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= OC_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    cmp_pin_mux u_mux (
        .mode_i      (mode),
        .state_i     (state_q),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o)
    );

    always_comb begin
        cmp_state_o = (state_q == OC_HIGH);
    end

endmodule

// File: rtl/cmp_pin_unit_chk.sv
module cmp_pin_unit_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       match_i,
    input logic       force_i,
    input logic       load_i,
    input logic       load_val_i,
    input logic       port_data_i,
    input logic       port_dir_i,
    input logic       pin_out_o,
    input logic       pin_oe_o,
    input logic       cmp_state_o
);

    logic stb;
    assign stb = match_i | force_i;

    AST_RESET_LOW: assert property (@(posedge clk_i)
        !rst_ni |=> !cmp_state_o); // R1

    AST_TOGGLE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && stb && mode_i == 2'b01) |=> (cmp_state_o != $past(cmp_state_o))); // R2

    AST_CLEAR_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && stb && mode_i == 2'b10) |=> !cmp_state_o); // R3

    AST_SET_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && stb && mode_i == 2'b11) |=> cmp_state_o); // R4

    AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && mode_i == 2'b00) |=> $stable(cmp_state_o)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cmp_state_o == $past(load_val_i))); // R8

    AST_PIN_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |-> (pin_out_o == ((mode_i != 2'b00) ? cmp_state_o : port_data_i))); // R9

    AST_OE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |-> (pin_oe_o == port_dir_i)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !stb) |=> $stable(cmp_state_o)); // R11

endmodule

bind cmp_pin_unit cmp_pin_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .match_i     (match_i),
    .force_i     (force_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .port_data_i (port_data_i),
    .port_dir_i  (port_dir_i),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .cmp_state_o (cmp_state_o)
);

// File: tb/cmp_pin_unit_bench.sv
module cmp_pin_unit_bench;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       match_i = 1'b0;
    logic       force_i = 1'b0;
    logic       load_i = 1'b0;
    logic       load_val_i = 1'b0;
    logic       port_data_i = 1'b0;
    logic       port_dir_i = 1'b0;
    logic       pin_out_o;
    logic       pin_oe_o;
    logic       cmp_state_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    cmp_pin_unit u_cmp_pin_unit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (mode_i),
        .match_i     (match_i),
        .force_i     (force_i),
        .load_i      (load_i),
        .load_val_i  (load_val_i),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o),
        .cmp_state_o (cmp_state_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Inputs are applied just after a falling edge. They are held across one
    // rising edge and then removed at the next falling edge.
    task automatic cycle(input logic m, input logic f, input logic ld, input logic lv);
        match_i = m; force_i = f; load_i = ld; load_val_i = lv;
        @(negedge clk_i);
        match_i = 1'b0; force_i = 1'b0; load_i = 1'b0;
    endtask

    task automatic put(input logic v);
        cycle(1'b0, 1'b0, 1'b1, v);
    endtask

    task automatic t_reset;
        check("R1", cmp_state_o, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", cmp_state_o, 1'b0);
    endtask

    task automatic t_toggle;
        mode_i = 2'b01;
        put(1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R2", cmp_state_o, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R2", cmp_state_o, 1'b0);
    endtask

    task automatic t_clear_set;
        mode_i = 2'b10; put(1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R3", cmp_state_o, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R3", cmp_state_o, 1'b0);
        mode_i = 2'b11; put(1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R4", cmp_state_o, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R4", cmp_state_o, 1'b1);
    endtask

    task automatic t_off;
        mode_i = 2'b00;
        put(1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0); check("R5", cmp_state_o, 1'b1);
        put(1'b0);
        cycle(1'b0, 1'b1, 1'b0, 1'b0); check("R5", cmp_state_o, 1'b0);
    endtask

    task automatic t_force;
        mode_i = 2'b01; put(1'b0);
        cycle(1'b0, 1'b1, 1'b0, 1'b0); check("R6", cmp_state_o, 1'b1);
        mode_i = 2'b10;
        cycle(1'b0, 1'b1, 1'b0, 1'b0); check("R6", cmp_state_o, 1'b0);
        mode_i = 2'b11;
        cycle(1'b0, 1'b1, 1'b0, 1'b0); check("R6", cmp_state_o, 1'b1);
    endtask

    task automatic t_both;
        mode_i = 2'b01; put(1'b0);
        cycle(1'b1, 1'b1, 1'b0, 1'b0); check("R7", cmp_state_o, 1'b1);
        cycle(1'b1, 1'b1, 1'b0, 1'b0); check("R7", cmp_state_o, 1'b0);
    endtask

    task automatic t_load;
        mode_i = 2'b11; put(1'b0);
        cycle(1'b1, 1'b0, 1'b1, 1'b0); check("R8", cmp_state_o, 1'b0);
        mode_i = 2'b10;
        cycle(1'b1, 1'b1, 1'b1, 1'b1); check("R8", cmp_state_o, 1'b1);
        mode_i = 2'b00;
        put(1'b0); check("R8", cmp_state_o, 1'b0);
    endtask

    task automatic t_pin;
        mode_i = 2'b00; port_dir_i = 1'b0;
        put(1'b1);
        port_data_i = 1'b0; #1;
        check("R9", pin_out_o, 1'b0);
        check("R10", pin_oe_o, 1'b0);
        port_data_i = 1'b1; #1;
        check("R9", pin_out_o, 1'b1);
        mode_i = 2'b10; port_data_i = 1'b0; #1;
        check("R9", pin_out_o, 1'b1);
        check("R10", pin_oe_o, 1'b0);
        port_dir_i = 1'b1; #1;
        check("R10", pin_oe_o, 1'b1);
        mode_i = 2'b00; #1;
        check("R10", pin_oe_o, 1'b1);
        @(negedge clk_i);
    endtask

    task automatic t_idle;
        mode_i = 2'b01; put(1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_i);
            check("R11", cmp_state_o, 1'b1);
        end
    endtask

    initial begin
        fork
            begin
                @(negedge clk_i);
                t_reset();
                t_toggle();
                t_clear_set();
                t_off();
                t_force();
                t_both();
                t_load();
                t_pin();
                t_idle();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk_i);
                if (!done) begin
                    n_run++; n_fail++;
                    $display("FAIL watchdog actual=timeout expected=completion");
                end
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule